// File: doc/BRIEF.md
# Successor-Index Next-Line Fetch Predictor

This block sits beside an instruction cache and supplies the index of the next cache line to fetch. Every 16-byte line (four 32-bit instructions) owns one entry in a side table. The entry holds a successor line index, a branch target line index and one 2-bit saturating counter for each pair of instructions. A fetch presents a line index, and one cycle later the block returns that line's successor index together with a line-level taken prediction. The front end uses the successor directly as its next fetch index, so no tag comparison is needed.

A fill unit initialises an entry when a line is brought into the cache. It supplies the branch target line and a static taken hint. Execute reports resolved branches, naming the line, the instruction pair, the outcome and the line that actually followed. The counters are adjusted on every report. The way the successor field is kept up to date depends on a mode parameter. In eager mode the field is rewritten whenever the line's taken prediction flips. In lazy mode every successor starts sequential and is corrected only when execute reports that a different line actually followed.

Top module: `sip_next_line_pred`

## Requirements
- R1: After reset every entry's successor is its own index plus one, and a fetch of any line reports not-taken (all counters reset to 1).
- R2: A fetch presented in one cycle yields pred_valid high in the next cycle, carrying that line's successor and prediction. pred_valid is low in any cycle that follows a cycle without a fetch.
- R3: In eager mode a fill with hint 1 sets both counters to 2 and the successor to fill_tgt. A fill with hint 0 sets both counters to 1 and the successor to the sequential index.
- R4: Each counter takes values 0 to 3. A taken outcome increments it and a not-taken outcome decrements it, and it saturates at 3 and at 0. Values 2 and 3 mean taken. upd_pair 0 selects instructions 0–1 and upd_pair 1 selects instructions 2–3.
- R5: pred_taken is 1 exactly when at least one of the line's two counters is 2 or 3.
- R6: In eager mode, an update that flips the line's taken prediction rewrites the successor to the stored target (now taken) or to the sequential index (now not-taken) in the same cycle. An update that does not flip it leaves the successor unchanged.
- R7: In lazy mode a fill always sets the successor to the sequential index. An update whose upd_next differs from the stored successor rewrites it to upd_next. Counters are updated exactly as in R4.
- R8: When a fetch and an update target the same line in the same cycle, the fetch returns the value from before the update. A fetch in the next cycle sees the new value.
- R9: When fill_valid and upd_valid are high in the same cycle, the fill is applied and the update is discarded.
- R10: The sequential index of the last line wraps to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_idx | input | IDX_W | Line being fetched |
| pred_valid | output | 1 | Prediction valid (one cycle after fetch) |
| pred_next | output | IDX_W | Successor line index for the next fetch |
| pred_taken | output | 1 | Line predicted to leave via a taken branch |
| fill_valid | input | 1 | Initialise an entry |
| fill_idx | input | IDX_W | Line being filled |
| fill_tgt | input | IDX_W | Branch target line of the filled line |
| fill_hint | input | 1 | Static taken hint |
| upd_valid | input | 1 | Resolved branch report |
| upd_idx | input | IDX_W | Line holding the resolved branch |
| upd_pair | input | PAIR_W | Instruction pair holding the branch |
| upd_taken | input | 1 | Actual outcome |
| upd_next | input | IDX_W | Line that actually followed |

## Verification
Fetch results are due exactly one clock after the request. The bench drives each request just after a falling edge and reads pred_valid, pred_next and pred_taken at the following falling edge. That edge lies past the single rising edge that captures the read. Fills and updates are written on the rising edge after they are driven, so their effect is checked by a fetch issued at the next falling edge and sampled one cycle later. The same-cycle case deliberately issues the fetch and the update together: it expects the old value at the first sample and the new value from a second fetch. One eager and one lazy instance receive identical stimulus. Both are compared with a bench model across full sweeps of a 16-line table.

// File: rtl/sip_pkg.sv
package sip_pkg;

   localparam int CTR_W = 2;
   typedef logic [CTR_W-1:0] ctr_t;

   localparam ctr_t CTR_WEAK_NT = 2'd1;
   localparam ctr_t CTR_WEAK_T  = 2'd2;
   localparam ctr_t CTR_MAX     = 2'd3;

   typedef enum logic {
      SUCC_EAGER = 1'b0,
      SUCC_LAZY  = 1'b1
   } succ_mode_e;

   function automatic ctr_t ctr_step(ctr_t c, logic taken);
      if (taken) return (c == CTR_MAX) ? c : c + ctr_t'(1);
      else       return (c == '0)      ? c : c - ctr_t'(1);
   endfunction

   function automatic logic ctr_is_taken(ctr_t c);
      return c[CTR_W-1];
   endfunction

endpackage

// File: rtl/sip_table.sv
module sip_table #(
   parameter int IDX_W = 10,
   parameter int CTR_BITS = 4,
   parameter logic [CTR_BITS-1:0] CTR_INIT = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic                rd_vld,
   output logic [IDX_W-1:0]    rd_succ,
   output logic [CTR_BITS-1:0] rd_ctr,
   input  logic [IDX_W-1:0]    lk_idx,
   output logic [IDX_W-1:0]    lk_succ,
   output logic [IDX_W-1:0]    lk_tgt,
   output logic [CTR_BITS-1:0] lk_ctr,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [IDX_W-1:0]    wr_succ,
   input  logic [IDX_W-1:0]    wr_tgt,
   input  logic [CTR_BITS-1:0] wr_ctr
);
   localparam int DEPTH = 1 << IDX_W;

   logic [IDX_W-1:0]    succ_q [DEPTH];
   logic [IDX_W-1:0]    tgt_q  [DEPTH];
   logic [CTR_BITS-1:0] ctr_q  [DEPTH];
   logic                rd_vld_q;
   logic [IDX_W-1:0]    rd_succ_q;
   logic [CTR_BITS-1:0] rd_ctr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            succ_q[i] <= IDX_W'(i + 1);
            tgt_q[i]  <= '0;
            ctr_q[i]  <= CTR_INIT;
         end
      end else if (wr_en) begin
         succ_q[wr_idx] <= wr_succ;
         tgt_q[wr_idx]  <= wr_tgt;
         ctr_q[wr_idx]  <= wr_ctr;
      end
   end

   // registered read: same-edge write is not yet visible (old value)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld_q  <= 1'b0;
         rd_succ_q <= '0;
         rd_ctr_q  <= '0;
      end else begin
         rd_vld_q <= rd_en;
         if (rd_en) begin
            rd_succ_q <= succ_q[rd_idx];
            rd_ctr_q  <= ctr_q[rd_idx];
         end
      end
   end

   assign rd_vld  = rd_vld_q;
   assign rd_succ = rd_succ_q;
   assign rd_ctr  = rd_ctr_q;
   assign lk_succ = succ_q[lk_idx];
   assign lk_tgt  = tgt_q[lk_idx];
   assign lk_ctr  = ctr_q[lk_idx];

   // write tracking for the visibility check
   logic                wseen_q;
   logic [IDX_W-1:0]    widx_q, wsucc_q;
   logic [CTR_BITS-1:0] wctr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wseen_q <= 1'b0;
         widx_q  <= '0;
         wsucc_q <= '0;
         wctr_q  <= '0;
      end else begin
         wseen_q <= wr_en;
         widx_q  <= wr_idx;
         wsucc_q <= wr_succ;
         wctr_q  <= wr_ctr;
      end
   end

   // R2
   rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_vld);
   // R2
   rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_vld);
   // R8
   write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wseen_q |-> (succ_q[widx_q] == wsucc_q && ctr_q[widx_q] == wctr_q));

endmodule

// File: rtl/sip_ctr_upd.sv
module sip_ctr_upd #(
   parameter int PAIRS = 2,
   parameter int PAIR_W = 1
) (
   input  logic [PAIRS*sip_pkg::CTR_W-1:0] old_ctr,
   input  logic [PAIR_W-1:0]               pair,
   input  logic                            taken,
   output logic [PAIRS*sip_pkg::CTR_W-1:0] new_ctr,
   output logic                            old_line_tk,
   output logic                            new_line_tk
);
   import sip_pkg::*;

   logic [PAIRS-1:0] old_tk_vec, new_tk_vec;

   for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      ctr_t cur;
      assign cur = old_ctr[g*CTR_W +: CTR_W];
      assign new_ctr[g*CTR_W +: CTR_W] =
         (pair == PAIR_W'(g)) ? ctr_step(cur, taken) : cur;
      assign old_tk_vec[g] = ctr_is_taken(cur);
      assign new_tk_vec[g] = ctr_is_taken(new_ctr[g*CTR_W +: CTR_W]);
   end

   assign old_line_tk = |old_tk_vec;
   assign new_line_tk = |new_tk_vec;

endmodule

// File: rtl/sip_succ_sel.sv
module sip_succ_sel #(
   parameter int IDX_W = 10,
   parameter sip_pkg::succ_mode_e MODE = sip_pkg::SUCC_EAGER
) (
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [IDX_W-1:0] old_succ,
   input  logic [IDX_W-1:0] tgt,
   input  logic             old_tk,
   input  logic             new_tk,
   input  logic [IDX_W-1:0] act_next,
   output logic [IDX_W-1:0] upd_succ,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [IDX_W-1:0] fill_tgt,
   input  logic             fill_hint,
   output logic [IDX_W-1:0] fill_succ
);
   logic [IDX_W-1:0] upd_seq, fill_seq;
   assign upd_seq  = upd_idx + IDX_W'(1);
   assign fill_seq = fill_idx + IDX_W'(1);

   if (MODE == sip_pkg::SUCC_EAGER) begin : g_eager
      logic unused_lazy;
      assign unused_lazy = ^act_next;
      assign upd_succ  = (old_tk == new_tk) ? old_succ
                       : (new_tk ? tgt : upd_seq);
      assign fill_succ = fill_hint ? fill_tgt : fill_seq;
   end else begin : g_lazy
      logic unused_eager;
      assign unused_eager = ^{upd_seq, tgt, old_tk, new_tk, fill_tgt, fill_hint};
      assign upd_succ  = (old_succ != act_next) ? act_next : old_succ;
      assign fill_succ = fill_seq;
   end

endmodule

// File: rtl/sip_next_line_pred.sv
module sip_next_line_pred #(
   parameter int IDX_W = 10,
   parameter int LINE_INSNS = 4,
   parameter int INSNS_PER_CTR = 2,
   parameter sip_pkg::succ_mode_e MODE = sip_pkg::SUCC_EAGER,
   localparam int PAIRS = LINE_INSNS / INSNS_PER_CTR,
   localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [IDX_W-1:0]  fetch_idx,
   output logic              pred_valid,
   output logic [IDX_W-1:0]  pred_next,
   output logic              pred_taken,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [IDX_W-1:0]  fill_tgt,
   input  logic              fill_hint,
   input  logic              upd_valid,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [PAIR_W-1:0] upd_pair,
   input  logic              upd_taken,
   input  logic [IDX_W-1:0]  upd_next
);
   import sip_pkg::*;

   localparam int CTR_BITS = PAIRS * CTR_W;
   localparam logic [CTR_BITS-1:0] INIT_NT = {PAIRS{CTR_WEAK_NT}};
   localparam logic [CTR_BITS-1:0] INIT_T  = {PAIRS{CTR_WEAK_T}};

   if (IDX_W < 2 || IDX_W > 14) begin : g_bad_idx
      $error("sip_next_line_pred: IDX_W out of range");
   end
   if (INSNS_PER_CTR < 1 || (LINE_INSNS % INSNS_PER_CTR) != 0) begin : g_bad_pair
      $error("sip_next_line_pred: LINE_INSNS must be a multiple of INSNS_PER_CTR");
   end

   logic [CTR_BITS-1:0] rd_ctr, lk_ctr, new_ctr, wr_ctr;
   logic [IDX_W-1:0]    rd_succ, lk_succ, lk_tgt, upd_succ, fill_succ;
   logic [IDX_W-1:0]    wr_idx, wr_succ, wr_tgt;
   logic                old_tk, new_tk, upd_go, wr_en;

   assign upd_go = upd_valid && !fill_valid;    // fill wins
   assign wr_en  = fill_valid || upd_valid;

   sip_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS), .CTR_INIT(INIT_NT)) u_table (
      .clk, .rst_n,
      .rd_en(fetch_valid), .rd_idx(fetch_idx), .rd_vld(pred_valid),
      .rd_succ, .rd_ctr,
      .lk_idx(upd_idx), .lk_succ, .lk_tgt, .lk_ctr,
      .wr_en, .wr_idx, .wr_succ, .wr_tgt, .wr_ctr
   );

   sip_ctr_upd #(.PAIRS(PAIRS), .PAIR_W(PAIR_W)) u_ctr (
      .old_ctr(lk_ctr), .pair(upd_pair), .taken(upd_taken),
      .new_ctr, .old_line_tk(old_tk), .new_line_tk(new_tk)
   );

   sip_succ_sel #(.IDX_W(IDX_W), .MODE(MODE)) u_succ (
      .upd_idx, .old_succ(lk_succ), .tgt(lk_tgt),
      .old_tk, .new_tk, .act_next(upd_next), .upd_succ,
      .fill_idx, .fill_tgt, .fill_hint, .fill_succ
   );

   always_comb begin
      if (fill_valid) begin
         wr_idx  = fill_idx;
         wr_succ = fill_succ;
         wr_tgt  = fill_tgt;
         wr_ctr  = fill_hint ? INIT_T : INIT_NT;
      end else begin
         wr_idx  = upd_idx;
         wr_succ = upd_succ;
         wr_tgt  = lk_tgt;
         wr_ctr  = new_ctr;
      end
   end

   logic [PAIRS-1:0] rd_tk_vec;
   for (genvar g = 0; g < PAIRS; g++) begin : g_tk
      assign rd_tk_vec[g] = ctr_is_taken(rd_ctr[g*CTR_W +: CTR_W]);
   end
   assign pred_taken = |rd_tk_vec;
   assign pred_next  = rd_succ;

   ctr_t sel_old, sel_new;
   assign sel_old = lk_ctr[upd_pair*CTR_W +: CTR_W];
   assign sel_new = new_ctr[upd_pair*CTR_W +: CTR_W];

   // R4
   ctr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && upd_taken) |-> (sel_new >= sel_old));
   // R4
   ctr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && !upd_taken) |-> (sel_new <= sel_old));

endmodule

// File: tb/test_sip_next_line_pred.sv
`timescale 1ns/1ps
module test_sip_next_line_pred;
   localparam int W = 4;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         fetch_valid = 1'b0, fill_valid = 1'b0, upd_valid = 1'b0;
   logic [W-1:0] fetch_idx = '0, fill_idx = '0, fill_tgt = '0, upd_idx = '0, upd_next = '0;
   logic         fill_hint = 1'b0, upd_taken = 1'b0;
   logic [0:0]   upd_pair = '0;
   logic         pv_e, pt_e, pv_l, pt_l;
   logic [W-1:0] pn_e, pn_l;

   sip_next_line_pred #(.IDX_W(W), .MODE(sip_pkg::SUCC_EAGER)) i_sip_next_line_pred (
      .clk, .rst_n, .fetch_valid, .fetch_idx,
      .pred_valid(pv_e), .pred_next(pn_e), .pred_taken(pt_e),
      .fill_valid, .fill_idx, .fill_tgt, .fill_hint,
      .upd_valid, .upd_idx, .upd_pair, .upd_taken, .upd_next);

   sip_next_line_pred #(.IDX_W(W), .MODE(sip_pkg::SUCC_LAZY)) i_sip_next_line_pred_lazy (
      .clk, .rst_n, .fetch_valid, .fetch_idx,
      .pred_valid(pv_l), .pred_next(pn_l), .pred_taken(pt_l),
      .fill_valid, .fill_idx, .fill_tgt, .fill_hint,
      .upd_valid, .upd_idx, .upd_pair, .upd_taken, .upd_next);

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   logic [W-1:0] se [N];
   logic [W-1:0] sl [N];
   logic [W-1:0] tg [N];
   logic [1:0]   c0 [N];
   logic [1:0]   c1 [N];

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] step(logic [1:0] c, logic tk);
      if (tk) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   function automatic logic m_tk(int i);
      return c0[i][1] | c1[i][1];
   endfunction

   function automatic logic [W-1:0] seq(int i);
      return W'(i + 1);
   endfunction

   function automatic logic [W-1:0] act_nx(int i, logic tk);
      return tk ? tg[i] : seq(i);
   endfunction

   task automatic m_upd(int i, logic p, logic tk, logic [W-1:0] nx);
      logic o;
      o = m_tk(i);
      if (p) c1[i] = step(c1[i], tk); else c0[i] = step(c0[i], tk);
      if (o != m_tk(i)) se[i] = m_tk(i) ? tg[i] : seq(i);
      if (sl[i] != nx) sl[i] = nx;
   endtask

   task automatic m_fill(int i, logic [W-1:0] t, logic h);
      tg[i] = t;
      c0[i] = h ? 2'd2 : 2'd1;
      c1[i] = c0[i];
      se[i] = h ? t : seq(i);
      sl[i] = seq(i);
   endtask

   // called at a falling edge; result sampled at the next falling edge
   task automatic fetch_chk(int i, string req);
      fetch_valid = 1'b1; fetch_idx = W'(i);
      @(negedge clk);
      fetch_valid = 1'b0;
      chk({req, " valid"}, int'(pv_e & pv_l), 1);
      chk({req, " eager next"}, int'(pn_e), int'(se[i]));
      chk({req, " lazy next"}, int'(pn_l), int'(sl[i]));
      chk({req, " taken"}, int'(pt_e), int'(m_tk(i)));
      chk({req, " lazy taken"}, int'(pt_l), int'(m_tk(i)));
   endtask

   task automatic do_upd(int i, logic p, logic tk);
      logic [W-1:0] nx;
      nx = act_nx(i, tk);
      upd_valid = 1'b1; upd_idx = W'(i); upd_pair = p; upd_taken = tk; upd_next = nx;
      @(negedge clk);
      upd_valid = 1'b0;
      m_upd(i, p, tk, nx);
   endtask

   task automatic do_fill(int i, logic [W-1:0] t, logic h);
      fill_valid = 1'b1; fill_idx = W'(i); fill_tgt = t; fill_hint = h;
      @(negedge clk);
      fill_valid = 1'b0;
      m_fill(i, t, h);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < N; i++) begin
         se[i] = seq(i); sl[i] = seq(i); tg[i] = '0; c0[i] = 2'd1; c1[i] = 2'd1;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pred_valid in reset", int'(pv_e | pv_l), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < N; i++) fetch_chk(i, "R1");
      // R10: last line wraps to 0
      fetch_chk(N - 1, "R10");
      chk("R10 wrap literal", int'(pn_e), 0);
      // R2: no fetch -> no valid
      @(negedge clk);
      chk("R2 idle valid", int'(pv_e | pv_l), 0);

      // R3 / R7: fill sweep
      for (int i = 0; i < N; i++) do_fill(i, W'(i * 7 + 3), i[0]);
      for (int i = 0; i < N; i++) fetch_chk(i, "R3");

      // R4: saturation on line 4 (hint 0), pair 1
      for (int k = 0; k < 5; k++) do_upd(4, 1'b1, 1'b1);
      fetch_chk(4, "R4 sat high");
      chk("R4 taken after sat", int'(pt_e), 1);
      do_upd(4, 1'b1, 1'b0);
      fetch_chk(4, "R4 3->2");
      chk("R4 still taken", int'(pt_e), 1);
      do_upd(4, 1'b1, 1'b0);
      fetch_chk(4, "R6 2->1 flip");
      chk("R6 back to seq", int'(pn_e), 5);
      for (int k = 0; k < 4; k++) do_upd(4, 1'b1, 1'b0);
      do_upd(4, 1'b1, 1'b1);
      fetch_chk(4, "R4 sat low");
      chk("R4 not taken after floor", int'(pt_e), 0);

      // R5 / R6 / R7: pseudo-random outcome sweep
      lfsr = 16'hACE1;
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < N; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_upd(i, lfsr[0], lfsr[3] | lfsr[5]);
            fetch_chk(i, "R6 R7 R5");
         end
      end

      // R8: same-cycle fetch and update of line 9
      do_fill(9, W'(2), 1'b0);
      fetch_valid = 1'b1; fetch_idx = W'(9);
      upd_valid = 1'b1; upd_idx = W'(9); upd_pair = 1'b0; upd_taken = 1'b1; upd_next = W'(2);
      @(negedge clk);
      fetch_valid = 1'b0; upd_valid = 1'b0;
      chk("R8 old eager", int'(pn_e), 10);
      chk("R8 old lazy", int'(pn_l), 10);
      chk("R8 old taken", int'(pt_e), 0);
      m_upd(9, 1'b0, 1'b1, W'(2));
      fetch_chk(9, "R8 new");
      chk("R8 new eager literal", int'(pn_e), 2);

      // R9: fill and update together; update to line 5 must be dropped
      do_fill(5, W'(12), 1'b1);
      fill_valid = 1'b1; fill_idx = W'(3); fill_tgt = W'(7); fill_hint = 1'b1;
      upd_valid = 1'b1; upd_idx = W'(5); upd_pair = 1'b0; upd_taken = 1'b0; upd_next = W'(6);
      @(negedge clk);
      fill_valid = 1'b0; upd_valid = 1'b0;
      m_fill(3, W'(7), 1'b1);
      fetch_chk(3, "R9 fill applied");
      fetch_chk(5, "R9 update dropped");
      do_upd(5, 1'b0, 1'b0);
      fetch_chk(5, "R9 pair1 keeps taken");
      chk("R9 literal still target", int'(pn_e), 12);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule